// File: doc/BRIEF.md
# Filter Output Conditioning and Accumulation Stage

This block sits between a filter's adder tree and the device output. Each clock it takes the adder tree's signed sum and conditions it. A sign-invert control turns it into its two's-complement negative. An active-low clear control forces it to zero. The conditioned value is held in a register for one stage.

It then goes into an output adder. The adder's second operand is picked by a feedback select. One choice is an external pipeline input, which lets several filter slices be chained into one longer filter. The other is the block's own registered result, which lets the stage build a running sum over many clocks.

All arithmetic is signed and of one parameterised width, 24 bits by default. It wraps on overflow. A synchronous reset clears both registers.

Top module: `filt_out_stage`

## Requirements
- R1: With `negateIn` low and `zeroN` high, the sum sampled at a rising edge is held unchanged as the conditioned value that enters the output adder.
- R2: With `zeroN` low, the conditioned value is zero whatever `negateIn` and `filterSum` are. The clear control takes priority over the sign-invert control.
- R3: With `zeroN` high and `negateIn` high, the conditioned value is the two's-complement negative of the sum. The most negative value maps to itself.
- R4: When `fbSel` is low at the edge where a conditioned value is added, `accOut` becomes that conditioned value plus the `pipeIn` sampled at the same edge.
- R5: When `fbSel` is high at that edge, `accOut` becomes the conditioned value plus the previous `accOut`.
- R6: Every addition and negation wraps modulo 2^W, with no saturation.
- R7: A sum sampled at rising edge k affects `accOut` right after edge k+1, and not before. The controls `negateIn`/`zeroN` are taken at edge k. The controls `fbSel`/`pipeIn` are taken at edge k+1.
- R8: `rst` high at a rising edge clears `accOut` and the conditioned register to zero. So the first edge after reset with `fbSel` low yields exactly `pipeIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| filterSum | input | W | Signed sum from the adder tree |
| negateIn | input | 1 | Sign-invert the sum when high |
| zeroN | input | 1 | Force the sum to zero when low |
| fbSel | input | 1 | Adder operand select: 1 = own output, 0 = `pipeIn` |
| pipeIn | input | W | Signed cascade input from a previous stage |
| accOut | output | W | Signed registered accumulator result |

## Verification
A sum and its negate/zero controls reach `accOut` two edges after they are applied. The feedback select and the pipeline input act one edge later, at the edge where the conditioned value enters the adder. The bench keeps a cycle-accurate reference of both registers. It advances the reference at each rising edge, using the inputs held across that edge. It then compares `accOut` at the following falling edge, so each result is judged in the cycle it is due. Directed cases cover the following:
- wrap of the most negative value
- adder overflow
- a single-sum latency probe
- the state right after reset

// File: rtl/filt_out_pkg.sv
package filt_out_pkg;

  // Strobes handed from the control decoder to the datapath
  typedef struct packed {
    logic doZero;       // force conditioned value to zero
    logic doNegate;     // two's-complement the sum
    logic useFeedback;  // adder takes own output instead of pipeIn
  } condStrobe_t;

endpackage

// File: rtl/filt_out_ctrl.sv
module filt_out_ctrl
  import filt_out_pkg::*;
(
  input  logic        negateIn,
  input  logic        zeroN,
  input  logic        fbSel,
  output condStrobe_t strobes
);

  always_comb begin
    strobes.doZero      = ~zeroN;
    // clear wins over invert (R2)
    strobes.doNegate    = negateIn & zeroN;
    strobes.useFeedback = fbSel;
  end

endmodule

// File: rtl/filt_out_dp.sv
module filt_out_dp
  import filt_out_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  condStrobe_t         strobes,
  input  logic signed [W-1:0] sumIn,
  input  logic signed [W-1:0] pipeIn,
  output logic signed [W-1:0] accOut
);

  localparam logic signed [W-1:0] ZERO_VAL = '0;

  logic signed [W-1:0] condNext;
  logic signed [W-1:0] condReg;
  logic signed [W-1:0] addOperand;
  logic signed [W-1:0] addResult;

  // Conditioning: clear has priority, then sign-invert
  always_comb begin
    if (strobes.doZero)        condNext = ZERO_VAL;
    else if (strobes.doNegate) condNext = ZERO_VAL - sumIn;
    else                       condNext = sumIn;
  end

  always_ff @(posedge clk) begin
    if (rst) condReg <= ZERO_VAL;
    else     condReg <= condNext;
  end

  assign addOperand = strobes.useFeedback ? accOut : pipeIn;
  assign addResult  = condReg + addOperand;   // wraps modulo 2^W

  always_ff @(posedge clk) begin
    if (rst) accOut <= ZERO_VAL;
    else     accOut <= addResult;
  end

  // R2: cleared sum reaches the conditioned register as zero
  a_r2_zero_wins: assert property (@(posedge clk) disable iff (rst)
    (strobes.doZero) |=> (condReg == ZERO_VAL));

  // R1: pass-through when neither control is active
  a_r1_pass: assert property (@(posedge clk) disable iff (rst)
    (!strobes.doZero && !strobes.doNegate) |=> (condReg == $past(sumIn)));

  // R3: negation, including the wrap at the most negative value (R6)
  a_r3_negate: assert property (@(posedge clk) disable iff (rst)
    (strobes.doNegate) |=> ((condReg + $past(sumIn)) == ZERO_VAL));

  // R5: self-feedback adds the previous output
  a_r5_feedback: assert property (@(posedge clk) disable iff (rst)
    (strobes.useFeedback) |=> (accOut - $past(accOut) == $past(condReg)));

  // R4: cascade path adds the pipeline input
  a_r4_cascade: assert property (@(posedge clk) disable iff (rst)
    (!strobes.useFeedback) |=> (accOut - $past(pipeIn) == $past(condReg)));

  // R8: reset clears both registers
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (accOut == ZERO_VAL && condReg == ZERO_VAL));

endmodule

// File: rtl/filt_out_stage.sv
module filt_out_stage
  import filt_out_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] filterSum,
  input  logic                negateIn,
  input  logic                zeroN,
  input  logic                fbSel,
  input  logic signed [W-1:0] pipeIn,
  output logic signed [W-1:0] accOut
);

  condStrobe_t strobes;

  filt_out_ctrl u_ctrl (
    .negateIn (negateIn),
    .zeroN    (zeroN),
    .fbSel    (fbSel),
    .strobes  (strobes)
  );

  filt_out_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .sumIn   (filterSum),
    .pipeIn  (pipeIn),
    .accOut  (accOut)
  );

  // R7: plain sum, then a cascade edge with zero pipeIn, shows the sum two edges later
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    (zeroN && !negateIn) ##1 (!fbSel && pipeIn == '0) |=> (accOut == $past(filterSum, 2)));

endmodule

// File: tb/tb_filt_out_stage.sv
module tb_filt_out_stage;

  localparam int W = 24;
  localparam logic signed [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAX_VAL = {1'b0, {(W-1){1'b1}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [W-1:0] filterSum = '0;
  logic negateIn = 1'b0;
  logic zeroN = 1'b1;
  logic fbSel = 1'b0;
  logic signed [W-1:0] pipeIn = '0;
  logic signed [W-1:0] accOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic signed [W-1:0] condExp = '0;
  logic signed [W-1:0] accExp = '0;

  always #10 clk = ~clk;   // 50 MHz

  filt_out_stage #(.W(W)) dut (
    .clk(clk), .rst(rst), .filterSum(filterSum), .negateIn(negateIn),
    .zeroN(zeroN), .fbSel(fbSel), .pipeIn(pipeIn), .accOut(accOut)
  );

  function automatic logic signed [W-1:0] condition(
      logic signed [W-1:0] s, logic neg, logic zn);
    if (!zn)     return '0;
    else if (neg) return -s;
    else          return s;
  endfunction

  function automatic logic signed [W-1:0] addStage(
      logic signed [W-1:0] c, logic fb, logic signed [W-1:0] prevOut,
      logic signed [W-1:0] p);
    return c + (fb ? prevOut : p);
  endfunction

  task automatic check(string tag, logic signed [W-1:0] act, logic signed [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: accOut=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, update model, compare at next falling edge
  task automatic step(logic signed [W-1:0] s, logic neg, logic zn, logic fb,
                      logic signed [W-1:0] p, string tag);
    filterSum = s; negateIn = neg; zeroN = zn; fbSel = fb; pipeIn = p;
    @(posedge clk);
    accExp  = addStage(condExp, fb, accExp, p);
    condExp = condition(s, neg, zn);
    @(negedge clk);
    check(tag, accOut, accExp);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    condExp = '0; accExp = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    check("R8 reset value", accOut, '0);

    // R8: cleared conditioned register means first output is pipeIn alone
    step(24'sd500, 1'b0, 1'b1, 1'b0, 24'sd77, "R8 first after reset");
    // R1/R7: the 500 shows now (pipeIn zero)
    step(24'sd0, 1'b0, 1'b0, 1'b0, 24'sd0, "R7 latency R1 pass");
    step(24'sd0, 1'b0, 1'b0, 1'b0, 24'sd0, "R7 after impulse");
    // R2: clear beats negate
    step(24'sd1234, 1'b1, 1'b0, 1'b0, 24'sd0, "R2 load");
    step(24'sd0, 1'b0, 1'b1, 1'b0, 24'sd0, "R2 zero wins over negate");
    // R3/R6: most negative value wraps to itself
    step(MIN_VAL, 1'b1, 1'b1, 1'b0, 24'sd0, "R3 load min");
    step(24'sd0, 1'b0, 1'b0, 1'b0, 24'sd0, "R3 R6 negate of min");
    // R3 ordinary negate
    step(24'sd321, 1'b1, 1'b1, 1'b0, 24'sd0, "R3 load");
    step(24'sd0, 1'b0, 1'b0, 1'b0, 24'sd0, "R3 negate");
    // R6: cascade overflow wrap
    step(MAX_VAL, 1'b0, 1'b1, 1'b0, 24'sd0, "R6 load max");
    step(24'sd0, 1'b0, 1'b0, 1'b0, 24'sd5, "R6 cascade wrap");
    // R5: accumulate a constant over several edges
    for (int i = 0; i < 6; i++)
      step(24'sd1000, 1'b0, 1'b1, 1'b1, 24'sd9999, "R5 accumulate");
    // R4: cascade discards own output
    step(24'sd0, 1'b0, 1'b1, 1'b0, -24'sd42, "R4 cascade");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic signed [W-1:0] s;
      logic signed [W-1:0] p;
      logic neg, zn, fb;
      string tag;
      s   = W'($urandom);
      p   = W'($urandom);
      if (($urandom % 8) == 0) s = (($urandom % 2) == 0) ? MIN_VAL : MAX_VAL;
      neg = 1'($urandom);
      zn  = (($urandom % 4) != 0);
      fb  = 1'($urandom);
      tag = fb ? "R5 R6 random feedback" : "R4 R6 random cascade";
      if (!zn)      tag = {tag, " R2"};
      else if (neg) tag = {tag, " R3"};
      else          tag = {tag, " R1"};
      step(s, neg, zn, fb, p, tag);
      if (($urandom % 500) == 0) begin
        doReset();
        check("R8 reset mid-run", accOut, '0);
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule